// File: doc/BRIEF.md
# Table-Driven Trigger Sequencer

This block is a small programmable state machine that fires converter group triggers and a processor interrupt on its own, with no processor involvement once started. Its program is a table of entries held in a register file. Each entry names an action (wait, advance or conditional branch), a condition code, a branch target, a delay count, a trigger mask and an interrupt flag. Software loads the table through a write port, sets the enable input, optionally writes the start-entry register, and then pulses the run input.

While running, the sequencer sits in one entry at a time. On entering an entry it emits that entry's trigger mask and interrupt flag for exactly one cycle and loads the delay counter from the entry's count field. Wait entries hold until their condition is true. Branch entries jump to their target when the condition is true and fall through when it is not. Advance entries move on after one cycle. The condition can be constant true, the delay counter reaching zero, a hardware trigger input or a status input such as a converter limit flag. Together these let timed trigger trains and event-driven loops run in hardware.

Top module: `tblseq_top`

## Requirements
- R1: After reset the sequencer is idle, trig_o and irq_o are zero, and the start-entry register holds 0.
- R2: run_i starts the sequencer only when en_i is high and the sequencer is idle; a run pulse while disabled or while already running has no effect.
- R3: A run starts execution at the entry held in the start-entry register, which is written by start_we_i with start_addr_i.
- R4: On every entry into a state, including a branch back to the same state, trig_o carries that entry's mask and irq_o its interrupt flag for exactly the first cycle spent in the state; in every other cycle both are zero.
- R5: A wait entry (action code 0) stays in its state while its condition is false and moves to the following entry on the clock edge that samples its condition true.
- R6: An advance entry (action code 1) moves to the following entry after one cycle, whatever its condition.
- R7: A branch entry (action code 2) moves after one cycle to its branch target if its condition is true, and to the following entry otherwise.
- R8: On entry the delay counter takes the entry's count N, then counts down by one per cycle and stops at zero; the counter-done condition is true while it is zero, so a wait on counter-done stays N+1 cycles.
- R9: Condition codes are 0 true, 1 counter done, 2 and 3 hw_trig_i bits 0 and 1, 4 and 5 stat_i bits 0 and 1; with the default parameters, codes 6 and 7 are never true.
- R10: The entry following entry DEPTH-1 is entry 0.
- R11: While en_i is low, trig_o and irq_o are zero in that same cycle and the sequencer returns to idle at the next edge; raising en_i again does not resume it without a new run.
- R12: A table word is laid out, from bit 0 upward, as action (2 bits), condition code (3), branch target (4), delay count (12), trigger mask (4) and interrupt flag (1), for 26 bits with default parameters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Enable level; low forces idle |
| run_i | input | 1 | Run command pulse |
| start_we_i | input | 1 | Write strobe for the start-entry register |
| start_addr_i | input | AW | Start-entry value to write |
| tbl_we_i | input | 1 | Table write strobe |
| tbl_addr_i | input | AW | Table write address |
| tbl_wdata_i | input | EW | Table write data, layout per R12 |
| hw_trig_i | input | HW_N | Hardware trigger condition inputs |
| stat_i | input | ST_N | Status condition inputs (e.g. limit flags) |
| trig_o | output | TRIG_N | Group trigger pulses |
| irq_o | output | 1 | Interrupt pulse |

## Verification
The bench builds the block with DEPTH 16, a 12-bit delay counter, four trigger outputs and two each of hardware and status inputs. With these values the six used condition codes leave codes 6 and 7 free, so a never-true wait gives a clean parking state, and a start at entry 14 makes the wrap from entry 15 to entry 0 reachable within a short loop. The short delay count of 3 makes the N+1 dwell exact to the cycle, and the loop also exercises disable mid-run and run pulses that must be ignored.

// File: rtl/tblseq_pkg.sv
package tblseq_pkg;

   typedef enum logic [1:0] {
      ACT_WAIT   = 2'd0,
      ACT_NEXT   = 2'd1,
      ACT_BRANCH = 2'd2,
      ACT_RSVD   = 2'd3
   } act_e;

   localparam int COND_TRUE  = 0;
   localparam int COND_CDONE = 1;
   localparam int COND_HW0   = 2;

endpackage

// File: rtl/tblseq_store.sv
module tblseq_store #(
   parameter int DEPTH = 16,
   parameter int EW    = 26,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          we_i,
   input  logic [AW-1:0] waddr_i,
   input  logic [EW-1:0] wdata_i,
   input  logic [AW-1:0] raddr_i,
   output logic [EW-1:0] rdata_o
);

   logic [EW-1:0] mem_q [DEPTH];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         mem_q <= '{default: '0};
      end else if (we_i) begin
         mem_q[waddr_i] <= wdata_i;
      end
   end

   assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/tblseq_cond.sv
module tblseq_cond #(
   parameter int HW_N   = 2,
   parameter int ST_N   = 2,
   localparam int CSEL_W = $clog2(2 + HW_N + ST_N),
   localparam int NCODE  = 1 << CSEL_W
) (
   input  logic [CSEL_W-1:0] sel_i,
   input  logic              cdone_i,
   input  logic [HW_N-1:0]   hw_i,
   input  logic [ST_N-1:0]   st_i,
   output logic              hit_o
);

   import tblseq_pkg::*;

   logic [NCODE-1:0] vec;

   always_comb begin
      vec             = '0;
      vec[COND_TRUE]  = 1'b1;
      vec[COND_CDONE] = cdone_i;
      for (int i = 0; i < HW_N; i++) vec[COND_HW0 + i] = hw_i[i];
      for (int j = 0; j < ST_N; j++) vec[COND_HW0 + HW_N + j] = st_i[j];
   end

   assign hit_o = vec[sel_i];

endmodule

// File: rtl/tblseq_dly.sv
module tblseq_dly #(
   parameter int CNT_W = 12
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             done_o
);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] eff;

   assign eff    = load_i ? load_val_i : cnt_q;
   assign done_o = (eff == '0);
   assign cnt_o  = cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cnt_q <= '0;
      else         cnt_q <= done_o ? '0 : eff - 1'b1;
   end

endmodule

// File: rtl/tblseq_top.sv
module tblseq_top #(
   parameter int DEPTH  = 16,
   parameter int CNT_W  = 12,
   parameter int TRIG_N = 4,
   parameter int HW_N   = 2,
   parameter int ST_N   = 2,
   localparam int AW      = $clog2(DEPTH),
   localparam int CSEL_W  = $clog2(2 + HW_N + ST_N),
   localparam int CSEL_LO = 2,
   localparam int BR_LO   = CSEL_LO + CSEL_W,
   localparam int CNT_LO  = BR_LO + AW,
   localparam int MASK_LO = CNT_LO + CNT_W,
   localparam int IRQ_BIT = MASK_LO + TRIG_N,
   localparam int EW      = IRQ_BIT + 1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              en_i,
   input  logic              run_i,
   input  logic              start_we_i,
   input  logic [AW-1:0]     start_addr_i,
   input  logic              tbl_we_i,
   input  logic [AW-1:0]     tbl_addr_i,
   input  logic [EW-1:0]     tbl_wdata_i,
   input  logic [HW_N-1:0]   hw_trig_i,
   input  logic [ST_N-1:0]   stat_i,
   output logic [TRIG_N-1:0] trig_o,
   output logic              irq_o
);

   import tblseq_pkg::*;

   if (DEPTH < 2 || CNT_W < 1 || TRIG_N < 1 || HW_N < 1 || ST_N < 1) begin : g_bad_cfg
      $error("tblseq_top: DEPTH>=2 and nonzero widths/counts required");
   end

   logic [AW-1:0]     start_q;
   logic [AW-1:0]     pc_q;
   logic              running_q;
   logic              enter_q;
   logic [EW-1:0]     cur;
   act_e              cur_act;
   logic [CSEL_W-1:0] cur_csel;
   logic [AW-1:0]     cur_br;
   logic [CNT_W-1:0]  cur_cnt;
   logic [TRIG_N-1:0] cur_mask;
   logic              cur_irq;
   logic              hit;
   logic              cdone;
   logic [CNT_W-1:0]  cnt_val;
   logic [AW-1:0]     seq_nxt;
   logic [AW-1:0]     tgt;
   logic              go;
   logic              start;
   logic              load;

   tblseq_store #(.DEPTH(DEPTH), .EW(EW)) u_store (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (tbl_we_i),
      .waddr_i (tbl_addr_i),
      .wdata_i (tbl_wdata_i),
      .raddr_i (pc_q),
      .rdata_o (cur)
   );

   assign cur_act  = act_e'(cur[1:0]);
   assign cur_csel = cur[CSEL_LO +: CSEL_W];
   assign cur_br   = cur[BR_LO +: AW];
   assign cur_cnt  = cur[CNT_LO +: CNT_W];
   assign cur_mask = cur[MASK_LO +: TRIG_N];
   assign cur_irq  = cur[IRQ_BIT];

   tblseq_dly #(.CNT_W(CNT_W)) u_dly (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (enter_q),
      .load_val_i (cur_cnt),
      .cnt_o      (cnt_val),
      .done_o     (cdone)
   );

   tblseq_cond #(.HW_N(HW_N), .ST_N(ST_N)) u_cond (
      .sel_i   (cur_csel),
      .cdone_i (cdone),
      .hw_i    (hw_trig_i),
      .st_i    (stat_i),
      .hit_o   (hit)
   );

   assign seq_nxt = (pc_q == AW'(DEPTH - 1)) ? '0 : pc_q + 1'b1;

   always_comb begin
      go  = 1'b0;
      tgt = seq_nxt;
      case (cur_act)
         ACT_WAIT:   go = hit;
         ACT_NEXT:   go = 1'b1;
         ACT_BRANCH: begin
            go  = 1'b1;
            tgt = hit ? cur_br : seq_nxt;
         end
         default:    go = 1'b0;
      endcase
   end

   assign start = en_i && run_i && !running_q;
   assign load  = start || (running_q && en_i && go);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         start_q <= '0;
      else if (start_we_i) start_q <= start_addr_i;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         running_q <= 1'b0;
         pc_q      <= '0;
         enter_q   <= 1'b0;
      end else if (!en_i) begin
         running_q <= 1'b0;
         enter_q   <= 1'b0;
      end else if (load) begin
         running_q <= 1'b1;
         pc_q      <= start ? start_q : tgt;
         enter_q   <= 1'b1;
      end else begin
         enter_q   <= 1'b0;
      end
   end

   assign trig_o = (enter_q && en_i) ? cur_mask : '0;
   assign irq_o  = enter_q && en_i && cur_irq;

endmodule

// File: rtl/tblseq_chk.sv
module tblseq_chk #(
   parameter int DEPTH  = 16,
   parameter int AW     = 4,
   parameter int CNT_W  = 12,
   parameter int TRIG_N = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              en,
   input logic              run,
   input logic              running,
   input logic              enter,
   input logic [AW-1:0]     pc,
   input logic [AW-1:0]     start_addr,
   input logic [1:0]        act,
   input logic              hit,
   input logic [CNT_W-1:0]  cnt_q,
   input logic [TRIG_N-1:0] trig,
   input logic              irq
);

   assert_start_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(running) |-> $past(en && run));

   assert_start_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(running) |-> pc == $past(start_addr));

   assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !running |-> (trig == '0 && !irq));

   assert_wait_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (running && en && act == 2'd0 && !hit) |=> (pc == $past(pc) && !enter));

   assert_count_down_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!enter && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);

   assert_pc_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
      int'(pc) < DEPTH);

   assert_dis_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> (trig == '0 && !irq));

   assert_dis_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !running);

endmodule

bind tblseq_top tblseq_chk #(
   .DEPTH(DEPTH), .AW(AW), .CNT_W(CNT_W), .TRIG_N(TRIG_N)
) u_chk (
   .clk        (clk_i),
   .rst_n      (rst_ni),
   .en         (en_i),
   .run        (run_i),
   .running    (running_q),
   .enter      (enter_q),
   .pc         (pc_q),
   .start_addr (start_q),
   .act        (cur[1:0]),
   .hit        (hit),
   .cnt_q      (cnt_val),
   .trig       (trig_o),
   .irq        (irq_o)
);

// File: tb/sim_tblseq_top.sv
`timescale 1ns/1ps
module sim_tblseq_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en = 1'b0;
   logic        run = 1'b0;
   logic        start_we = 1'b0;
   logic [3:0]  start_addr = '0;
   logic        tbl_we = 1'b0;
   logic [3:0]  tbl_addr = '0;
   logic [25:0] tbl_wdata = '0;
   logic [1:0]  hw = '0;
   logic [1:0]  st = '0;
   logic [3:0]  trig;
   logic        irq;

   int cyc = 0;
   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   typedef struct {
      int    c;
      int    tr;
      int    ir;
      string req;
   } ev_t;
   ev_t expq[$];

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   tblseq_top #(.DEPTH(16), .CNT_W(12), .TRIG_N(4), .HW_N(2), .ST_N(2)) u0 (
      .clk_i(clk), .rst_ni(rst_n), .en_i(en), .run_i(run),
      .start_we_i(start_we), .start_addr_i(start_addr),
      .tbl_we_i(tbl_we), .tbl_addr_i(tbl_addr), .tbl_wdata_i(tbl_wdata),
      .hw_trig_i(hw), .stat_i(st), .trig_o(trig), .irq_o(irq)
   );

   // R12 word layout: act[1:0] csel[4:2] br[8:5] cnt[20:9] mask[24:21] irq[25]
   function automatic logic [25:0] ent(int act, int cs, int br, int cnt, int mask, int ir);
      return {1'(ir), 4'(mask), 12'(cnt), 4'(br), 3'(cs), 2'(act)};
   endfunction

   task automatic chk(bit ok, string req, int act, int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic push(int c, int tr, int ir, string req);
      ev_t e;
      e.c = c; e.tr = tr; e.ir = ir; e.req = req;
      expq.push_back(e);
   endtask

   task automatic wr(int a, logic [25:0] d);
      tbl_we = 1'b1; tbl_addr = 4'(a); tbl_wdata = d;
      @(negedge clk);
      tbl_we = 1'b0;
   endtask

   task automatic set_start(int a);
      start_we = 1'b1; start_addr = 4'(a);
      @(negedge clk);
      start_we = 1'b0;
   endtask

   task automatic pulse_run();
      run = 1'b1;
      @(negedge clk);
      run = 1'b0;
   endtask

   // monitor: compares every trigger/interrupt event with the scoreboard
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (rst_n && (trig != '0 || irq)) begin
            if (expq.size() == 0) begin
               n_run++; n_fail++;
               $display("FAIL R2/R11 unexpected event at %0d: actual trig %0d irq %0d expected none",
                        cyc, trig, irq);
            end else begin
               ev_t e;
               e = expq.pop_front();
               chk(e.c == cyc && e.tr == int'(trig) && e.ir == int'(irq), e.req,
                   cyc * 100 + int'(trig) * 2 + int'(irq), e.c * 100 + e.tr * 2 + e.ir);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      int t0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      for (int i = 0; i < 3; i++) begin
         #1;
         chk(trig == '0, "R1 trig", int'(trig), 0);
         @(negedge clk);
      end
      chk(irq == 1'b0, "R1 irq", int'(irq), 0);

      // Test A: default start entry 0, advance, counter wait, never-true park
      wr(0, ent(1, 0, 0, 0, 1, 0));
      wr(1, ent(0, 1, 0, 3, 0, 0));
      wr(2, ent(1, 0, 0, 0, 2, 1));
      wr(3, ent(0, 7, 0, 0, 0, 0));
      en = 1'b1;
      @(negedge clk);
      t0 = cyc;
      push(t0 + 1, 1, 0, "R1 R3 R4 R6 start at default entry 0");
      push(t0 + 6, 2, 1, "R8 counter dwell N+1");
      pulse_run();
      repeat (10) @(negedge clk);
      pulse_run();                 // R2: ignored while running
      repeat (5) @(negedge clk);
      chk(expq.size() == 0, "R8 R9 scoreboard drained A", expq.size(), 0);
      en = 1'b0;
      repeat (2) @(negedge clk);

      // Test B: start register, hw wait, status branch taken and not taken
      wr(4, ent(0, 2, 0, 0, 0, 0));
      wr(5, ent(1, 0, 0, 0, 4, 0));
      wr(6, ent(2, 4, 4, 0, 0, 0));
      wr(7, ent(1, 0, 0, 0, 8, 0));
      wr(8, ent(0, 7, 0, 0, 0, 0));
      set_start(4);
      st = 2'b01;
      en = 1'b1;
      @(negedge clk);
      pulse_run();
      repeat (5) @(negedge clk);
      t0 = cyc;
      push(t0 + 1, 4, 0, "R5 R9 hw wait released");
      hw = 2'b01;
      @(negedge clk);
      hw = 2'b00;
      repeat (4) @(negedge clk);
      st = 2'b00;
      t0 = cyc;
      push(t0 + 1, 4, 0, "R5 R7 branch taken back to 4");
      push(t0 + 3, 8, 0, "R7 branch false falls through");
      hw = 2'b01;
      @(negedge clk);
      hw = 2'b00;
      repeat (6) @(negedge clk);
      chk(expq.size() == 0, "R7 scoreboard drained B", expq.size(), 0);
      en = 1'b0;
      repeat (2) @(negedge clk);

      // Test C: wrap 15 -> 0, endless loop, disable mid-loop
      wr(14, ent(1, 0, 0, 0, 1, 0));
      wr(15, ent(1, 0, 0, 0, 2, 0));
      wr(0, ent(2, 0, 14, 0, 4, 1));
      set_start(14);
      en = 1'b1;
      @(negedge clk);
      t0 = cyc;
      push(t0 + 1, 1, 0, "R3 start at 14");
      push(t0 + 2, 2, 0, "R6 advance");
      push(t0 + 3, 4, 1, "R10 wrap to entry 0");
      push(t0 + 4, 1, 0, "R7 R4 loop back");
      push(t0 + 5, 2, 0, "R4 loop");
      pulse_run();
      while (cyc != t0 + 6) @(negedge clk);
      en = 1'b0;                   // R11: suppresses the entry due now
      repeat (4) @(negedge clk);
      en = 1'b1;                   // R11: no resume without run
      repeat (5) @(negedge clk);
      en = 1'b0;
      pulse_run();                 // R2: run while disabled ignored
      en = 1'b1;
      repeat (5) @(negedge clk);
      chk(expq.size() == 0, "R11 R10 scoreboard drained C", expq.size(), 0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule